// File: doc/BRIEF.md
# Gate Driver Fault Supervisor

This block watches the fault flags of a two-half-bridge gate driver: one short-circuit comparator flag and one undervoltage flag for every power switch, plus a pair of overtemperature flags. It produces a shutdown mask, one bit per switch, that the gate sequencer uses to force the switch off, and a two-bit diagnostic code meant for open-drain flag pins (a 1 means the pin is released and reads high).

A short circuit counts only after it has been seen for a programmable number of consecutive clock cycles. Once it qualifies, both switches of that half-bridge are held off until a diagnostic clear. An undervoltage turns off only its own switch, which comes back by itself when the flag drops. Overtemperature never turns anything off; it only changes the diagnostic code. Raising the inhibit input re-initialises every piece of state. All inputs are taken to be synchronised single-bit flags.

Switch numbering: half-bridge h owns switches 2h (high side) and 2h+1 (low side).

Top module: `fault_supervisor`

## Requirements
- R1: A short-circuit flag trips its half-bridge when it has been sampled high at `filt_cycles_i` consecutive clock edges (a value of 0 acts as 1); the mask shows the trip right after the edge that completes the run.
- R2: The qualifying run is not accumulated: any edge at which the flag is sampled low restarts it, so shorter repeated pulses never trip.
- R3: A trip on either switch of half-bridge h sets both mask bits 2h and 2h+1 and leaves the other half-bridge untouched.
- R4: A trip stays latched until `diag_clr_i` is sampled high; that clear also restarts every qualifying run but leaves undervoltage and overtemperature state as they are.
- R5: `sw_off_o[k]` goes high one edge after `uv_i[k]` is sampled high, affects only switch k, and drops one edge after `uv_i[k]` is sampled low (unless a trip holds it).
- R6: With no fault present the code {er1_o, er2_o} is 2'b11, and it is 2'b11 out of reset.
- R7: The overtemperature warning sets when `ot_hot_i` is sampled high and clears only when `ot_cool_i` is sampled high with `ot_hot_i` low; alone it gives code 2'b10 and no mask bit.
- R8: A latched trip without undervoltage gives code 2'b01, whatever the overtemperature state.
- R9: Any active undervoltage gives code 2'b00, overriding trip and warning codes.
- R10: `inhibit_i` sampled high clears trips, qualifying runs, undervoltage state and the warning, so the next cycle shows mask 0 and code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inhibit_i | input | 1 | Full re-initialisation request |
| diag_clr_i | input | 1 | Clears latched short-circuit trips |
| filt_cycles_i | input | CNT_W | Short-circuit qualifying time in cycles |
| sc_i | input | NUM_SW | Short-circuit comparator flag per switch |
| uv_i | input | NUM_SW | Undervoltage flag per switch |
| ot_hot_i | input | 1 | Overtemperature set threshold crossed |
| ot_cool_i | input | 1 | Overtemperature clear threshold crossed |
| sw_off_o | output | NUM_SW | Forced-off mask per switch |
| er1_o | output | 1 | Diagnostic flag 1 (high = released) |
| er2_o | output | 1 | Diagnostic flag 2 (high = released) |

## Verification
Every result of this block is due exactly one clock edge after the input that causes it is sampled; a short-circuit trip is due at the edge that completes the qualifying run, which is `filt_cycles_i` edges after the flag first goes high. The bench changes inputs on the falling edge, lets a cycle-level reference model advance on the rising edge, and compares the mask and both flags on the following falling edge, so every expectation lines up with the one register stage in the design. Directed sequences count edges explicitly around the run boundary (one edge short, exact, broken by a single low sample).

// File: rtl/fault_sup_pkg.sv
package fault_sup_pkg;
  // {er1, er2}; 1 = pin released
  typedef enum logic [1:0] {
    ER_OK = 2'b11,
    ER_OT = 2'b10,
    ER_SC = 2'b01,
    ER_UV = 2'b00
  } er_code_e;
endpackage

// File: rtl/fault_sc_filter.sv
module fault_sc_filter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             sc_i,
  input  logic [CNT_W-1:0] filt_i,
  output logic             qual_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_nxt, filt_eff;

  assign filt_eff = (filt_i == '0) ? CNT_W'(1) : filt_i;

  always_comb begin
    if (!sc_i)                cnt_nxt = '0;
    else if (cnt_q == CNT_MAX) cnt_nxt = CNT_MAX;
    else                      cnt_nxt = cnt_q + CNT_W'(1);
  end

  assign qual_o = sc_i && !clr_i && (cnt_nxt >= filt_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/fault_ot_warn.sv
module fault_ot_warn (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inhibit_i,
  input  logic hot_i,
  input  logic cool_i,
  output logic warn_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        warn_o <= 1'b0;
    else if (inhibit_i) warn_o <= 1'b0;
    else if (hot_i)     warn_o <= 1'b1;
    else if (cool_i)    warn_o <= 1'b0;
  end
endmodule

// File: rtl/fault_diag_enc.sv
module fault_diag_enc
  import fault_sup_pkg::*;
(
  input  logic any_uv_i,
  input  logic any_trip_i,
  input  logic ot_i,
  output logic er1_o,
  output logic er2_o
);
  er_code_e code;

  always_comb begin
    if (any_uv_i)        code = ER_UV;
    else if (any_trip_i) code = ER_SC;
    else if (ot_i)       code = ER_OT;
    else                 code = ER_OK;
  end

  assign {er1_o, er2_o} = code;
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int NUM_HB = 2,
  parameter int CNT_W  = 8,
  localparam int NUM_SW = 2 * NUM_HB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inhibit_i,
  input  logic              diag_clr_i,
  input  logic [CNT_W-1:0]  filt_cycles_i,
  input  logic [NUM_SW-1:0] sc_i,
  input  logic [NUM_SW-1:0] uv_i,
  input  logic              ot_hot_i,
  input  logic              ot_cool_i,
  output logic [NUM_SW-1:0] sw_off_o,
  output logic              er1_o,
  output logic              er2_o
);
  logic              clr;
  logic [NUM_SW-1:0] qual;
  logic [NUM_SW-1:0] uv_q;
  logic [NUM_HB-1:0] trip_q;
  logic              ot_warn;

  assign clr = inhibit_i | diag_clr_i;

  for (genvar k = 0; k < NUM_SW; k++) begin : g_sw
    fault_sc_filter #(.CNT_W(CNT_W)) u_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .sc_i   (sc_i[k]),
      .filt_i (filt_cycles_i),
      .qual_o (qual[k])
    );
    assign sw_off_o[k] = trip_q[k/2] | uv_q[k];
  end

  for (genvar h = 0; h < NUM_HB; h++) begin : g_hb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        trip_q[h] <= 1'b0;
      else if (clr)                       trip_q[h] <= 1'b0;
      else if (qual[2*h] | qual[2*h+1])   trip_q[h] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        uv_q <= '0;
    else if (inhibit_i) uv_q <= '0;
    else                uv_q <= uv_i;
  end

  fault_ot_warn u_ot (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inhibit_i (inhibit_i),
    .hot_i     (ot_hot_i),
    .cool_i    (ot_cool_i),
    .warn_o    (ot_warn)
  );

  fault_diag_enc u_enc (
    .any_uv_i   (|uv_q),
    .any_trip_i (|trip_q),
    .ot_i       (ot_warn),
    .er1_o      (er1_o),
    .er2_o      (er2_o)
  );
endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk #(
  parameter int NUM_HB = 2,
  localparam int NUM_SW = 2 * NUM_HB
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              inhibit_i,
  input logic              diag_clr_i,
  input logic [NUM_SW-1:0] sc_i,
  input logic [NUM_SW-1:0] uv_i,
  input logic [NUM_SW-1:0] sw_off_o,
  input logic [NUM_HB-1:0] trip_hb,
  input logic              er1_o,
  input logic              er2_o
);
  for (genvar h = 0; h < NUM_HB; h++) begin : g_hb
    p_trip_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trip_hb[h] && !diag_clr_i && !inhibit_i |=> trip_hb[h]);
    p_trip_cause_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(trip_hb[h]) |-> ($past(sc_i[2*h]) || $past(sc_i[2*h+1])));
    p_trip_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trip_hb[h] |-> (sw_off_o[2*h] && sw_off_o[2*h+1]));
  end

  for (genvar k = 0; k < NUM_SW; k++) begin : g_sw
    p_uv_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      uv_i[k] && !inhibit_i |=> sw_off_o[k]);
    p_uv_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !uv_i[k] && !trip_hb[k/2] && !sc_i[2*(k/2)] && !sc_i[2*(k/2)+1] |=> !sw_off_o[k]);
  end

  p_uv_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|uv_i) && !inhibit_i |=> (!er1_o && !er2_o));
  p_released_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    er1_o |-> (sw_off_o == '0));
  p_inhibit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |=> (sw_off_o == '0 && er1_o && er2_o));
endmodule

bind fault_supervisor fault_supervisor_chk #(.NUM_HB(NUM_HB)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .inhibit_i  (inhibit_i),
  .diag_clr_i (diag_clr_i),
  .sc_i       (sc_i),
  .uv_i       (uv_i),
  .sw_off_o   (sw_off_o),
  .trip_hb    (trip_q),
  .er1_o      (er1_o),
  .er2_o      (er2_o)
);

// File: tb/fault_supervisor_test.sv
module fault_supervisor_test;
  localparam int NUM_HB = 2;
  localparam int NUM_SW = 2 * NUM_HB;
  localparam int CNT_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              inhibit = 1'b0, diag_clr = 1'b0, ot_hot = 1'b0, ot_cool = 1'b0;
  logic [CNT_W-1:0]  filt = 8'd3;
  logic [NUM_SW-1:0] sc = '0, uv = '0;
  logic [NUM_SW-1:0] sw_off;
  logic              er1, er2;

  int errors = 0;
  int checks = 0;
  string tag = "R6";

  always #2 clk = ~clk;

  fault_supervisor #(.NUM_HB(NUM_HB), .CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .inhibit_i(inhibit), .diag_clr_i(diag_clr),
    .filt_cycles_i(filt), .sc_i(sc), .uv_i(uv), .ot_hot_i(ot_hot),
    .ot_cool_i(ot_cool), .sw_off_o(sw_off), .er1_o(er1), .er2_o(er2));

  // reference model, cycle level
  int m_run [NUM_SW];
  bit m_trip [NUM_HB];
  bit [NUM_SW-1:0] m_uv;
  bit m_ot;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_SW; k++) m_run[k] = 0;
      for (int h = 0; h < NUM_HB; h++) m_trip[h] = 0;
      m_uv = '0; m_ot = 0;
    end else if (inhibit) begin
      for (int k = 0; k < NUM_SW; k++) m_run[k] = 0;
      for (int h = 0; h < NUM_HB; h++) m_trip[h] = 0;
      m_uv = '0; m_ot = 0;
    end else begin
      m_uv = uv;
      if (ot_hot) m_ot = 1; else if (ot_cool) m_ot = 0;
      if (diag_clr) begin
        for (int k = 0; k < NUM_SW; k++) m_run[k] = 0;
        for (int h = 0; h < NUM_HB; h++) m_trip[h] = 0;
      end else begin
        for (int k = 0; k < NUM_SW; k++) begin
          m_run[k] = sc[k] ? m_run[k] + 1 : 0;
          if (sc[k] && m_run[k] >= ((filt == 0) ? 1 : int'(filt))) m_trip[k/2] = 1;
        end
      end
    end
  end

  function automatic logic [NUM_SW-1:0] exp_mask();
    logic [NUM_SW-1:0] m;
    for (int k = 0; k < NUM_SW; k++) m[k] = m_trip[k/2] | m_uv[k];
    return m;
  endfunction

  function automatic logic [1:0] exp_code();
    bit t = 0;
    for (int h = 0; h < NUM_HB; h++) t |= m_trip[h];
    if (|m_uv) return 2'b00;
    if (t)     return 2'b01;
    if (m_ot)  return 2'b10;
    return 2'b11;
  endfunction

  task automatic check(string t, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", t, act, exp, $time);
    end
  endtask

  // advance one cycle, compare against model at the falling edge
  task automatic tick();
    @(negedge clk);
    check(tag, {2'b0, sw_off, er1, er2}, {2'b0, exp_mask(), exp_code()});
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    #1;
    check("R6 reset", {2'b0, sw_off, er1, er2}, {2'b0, 4'b0000, 2'b11});
    #9 rst_n = 1'b1;
    ticks(3);
    check("R6 idle", {2'b0, sw_off, er1, er2}, {2'b0, 4'b0000, 2'b11});

    // R1: exact qualifying run of 3
    tag = "R1"; filt = 8'd3; sc[0] = 1'b1;
    ticks(2);
    check("R1 one short", {2'b0, sw_off, er1, er2}, {2'b0, 4'b0000, 2'b11});
    tick();
    check("R1 trip", {2'b0, sw_off, er1, er2}, {2'b0, 4'b0011, 2'b01});
    sc[0] = 1'b0; ticks(4);
    check("R4 latched", {2'b0, sw_off, er1, er2}, {2'b0, 4'b0011, 2'b01});
    tag = "R4"; diag_clr = 1'b1; tick(); diag_clr = 1'b0;
    check("R4 cleared", {2'b0, sw_off, er1, er2}, {2'b0, 4'b0000, 2'b11});

    // R2: broken runs never qualify
    tag = "R2";
    for (int r = 0; r < 4; r++) begin
      sc[1] = 1'b1; ticks(2); sc[1] = 1'b0; tick();
    end
    check("R2 no accumulate", {2'b0, sw_off, er1, er2}, {2'b0, 4'b0000, 2'b11});

    // R1: zero acts as one
    tag = "R1"; filt = 8'd0; sc[1] = 1'b1; tick(); sc[1] = 1'b0;
    check("R1 filt zero", {2'b0, sw_off, er1, er2}, {2'b0, 4'b0011, 2'b01});
    diag_clr = 1'b1; tick(); diag_clr = 1'b0;

    // R3: other half-bridge
    tag = "R3"; filt = 8'd2; sc[3] = 1'b1; ticks(2); sc[3] = 1'b0;
    check("R3 pair", {2'b0, sw_off, er1, er2}, {2'b0, 4'b1100, 2'b01});
    diag_clr = 1'b1; tick(); diag_clr = 1'b0;

    // R5: undervoltage per switch, self recovery
    tag = "R5"; uv[2] = 1'b1; tick();
    check("R5 uv off", {2'b0, sw_off, er1, er2}, {2'b0, 4'b0100, 2'b00});
    uv[2] = 1'b0; tick();
    check("R5 uv release", {2'b0, sw_off, er1, er2}, {2'b0, 4'b0000, 2'b11});

    // R9: uv overrides trip code
    tag = "R9"; filt = 8'd1; sc[0] = 1'b1; uv[3] = 1'b1; tick(); sc[0] = 1'b0;
    check("R9 uv priority", {2'b0, sw_off, er1, er2}, {2'b0, 4'b1011, 2'b00});
    uv[3] = 1'b0; tick();
    check("R8 after uv", {2'b0, sw_off, er1, er2}, {2'b0, 4'b0011, 2'b01});
    diag_clr = 1'b1; tick(); diag_clr = 1'b0;

    // R7: warning with hysteresis
    tag = "R7"; ot_hot = 1'b1; tick(); ot_hot = 1'b0;
    check("R7 warn", {2'b0, sw_off, er1, er2}, {2'b0, 4'b0000, 2'b10});
    ticks(3);
    check("R7 hold", {2'b0, sw_off, er1, er2}, {2'b0, 4'b0000, 2'b10});

    // R8: trip code beats warning
    tag = "R8"; sc[2] = 1'b1; tick(); sc[2] = 1'b0;
    check("R8 sc code", {2'b0, sw_off, er1, er2}, {2'b0, 4'b1100, 2'b01});

    // R4: clear keeps uv and warning
    tag = "R4"; uv[0] = 1'b1; diag_clr = 1'b1; tick(); diag_clr = 1'b0;
    check("R4 keeps uv", {2'b0, sw_off, er1, er2}, {2'b0, 4'b0001, 2'b00});
    uv[0] = 1'b0; tick();
    check("R4 keeps ot", {2'b0, sw_off, er1, er2}, {2'b0, 4'b0000, 2'b10});
    tag = "R7"; ot_cool = 1'b1; tick(); ot_cool = 1'b0;
    check("R7 cool", {2'b0, sw_off, er1, er2}, {2'b0, 4'b0000, 2'b11});

    // R10: inhibit wipes everything
    tag = "R10"; ot_hot = 1'b1; sc[1] = 1'b1; uv[1] = 1'b1; tick();
    ot_hot = 1'b0; uv[1] = 1'b0; sc[1] = 1'b0; inhibit = 1'b1; tick(); inhibit = 1'b0;
    check("R10 inhibit", {2'b0, sw_off, er1, er2}, {2'b0, 4'b0000, 2'b11});

    // constrained random against the model (R1 R2 R3 R5 R7 R8 R9)
    tag = "RND_R1";
    filt = 8'd3;
    for (int n = 0; n < 4000; n++) begin
      for (int k = 0; k < NUM_SW; k++) begin
        if (sc[k]) sc[k] = ($urandom % 5) != 0;
        else       sc[k] = ($urandom % 12) == 0;
        if (($urandom % 40) == 0) uv[k] = ~uv[k];
      end
      diag_clr = ($urandom % 30) == 0;
      inhibit  = ($urandom % 250) == 0;
      ot_hot   = ($urandom % 60) == 0;
      ot_cool  = ($urandom % 45) == 0;
      if (($urandom % 100) == 0) filt = CNT_W'($urandom % 7);
      tick();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule